// File: doc/BRIEF.md
# Data Memory Address Remapping Unit

This block turns the file-register operand of an 8-bit microcontroller instruction into a 12-bit physical data memory address. It resolves three ways of reaching memory: a banked direct access that joins a 4-bit bank number to the operand, a fixed access map that splits the operand space between the bottom of bank 0 and the special function register region at the top of memory, and an extended mode in which the low part of that access map is redirected to a window that begins at a movable 12-bit pointer.

Accesses flagged as using an indirect file operand are never sent through the window. They take the fixed access map and raise a bypass output so that the downstream indirect-addressing logic handles them. The address and the bypass flag are registered once, so both reflect the inputs sampled at the previous rising clock edge.

Top module: `dmem_addr_remap`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `phys_addr_o` = 000h and `ind_bypass_o` = 0.
- R2: With `acc_bank_i` = 1, the address is `{bsr_i, opnd_i}` (bank in bits 11:8, operand in bits 7:0) whatever `ext_en_i`, `ptr_i` and `ind_op_i` are.
- R3: With `acc_bank_i` = 0, operand 00h–5Fh and either `ext_en_i` = 0 or `ind_op_i` = 1, the address is 000h plus the operand, inside bank 0.
- R4: With `acc_bank_i` = 0 and operand 60h–FFh, the address is F00h plus the operand (F60h–FFFh), in both modes.
- R5: With `acc_bank_i` = 0, `ext_en_i` = 1, `ind_op_i` = 0 and operand 00h–5Fh, the address is `ptr_i` plus the operand modulo 4096, so a window near the top of memory wraps to the bottom.
- R6: `ind_bypass_o` equals the `ind_op_i` value of the same sampled cycle, and a flagged access is never placed in the window.
- R7: Each output changes only at a rising clock edge and reflects the inputs present at that edge.
- R8: In extended mode with access bit 0, operand 5Fh is the last windowed offset (pointer + 5Fh) and operand 60h already selects F60h.
- R9: In extended mode, a bank 0 location hidden by the window stays reachable with `acc_bank_i` = 1 and `bsr_i` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 8 | File register operand from the instruction |
| acc_bank_i | input | 1 | 1 selects banked direct access, 0 selects the access map |
| bsr_i | input | 4 | Bank select value |
| ptr_i | input | 12 | Window base pointer |
| ext_en_i | input | 1 | Extended mode enable (windowed access map) |
| ind_op_i | input | 1 | Access uses an indirect file operand |
| phys_addr_o | output | 12 | Registered physical data memory address |
| ind_bypass_o | output | 1 | Registered flag: access goes to indirect handling |

## Verification
The window redirection and the indirect bypass are both asked for in one cycle whenever extended mode is on, the access bit is clear, the operand is below 60h and the indirect flag is set. The sweep walks every operand under every combination of access bit, mode and indirect flag for several pointer and bank values, so this collision occurs for each low operand. It is judged correct when the bypass output is high and the address equals the plain bank 0 location rather than pointer plus operand. A separate wrap case, with the pointer near FFFh, confirms that the window sum drops its carry.

// File: rtl/dmem_remap_pkg.sv
package dmem_remap_pkg;

  localparam int unsigned DEF_ADDR_W   = 12;
  localparam int unsigned DEF_OPND_W   = 8;
  localparam int unsigned DEF_WIN_SPAN = 96;

  typedef enum logic [1:0] {
    PATH_BANKED = 2'd0,
    PATH_LOW0   = 2'd1,
    PATH_WINDOW = 2'd2,
    PATH_SFR    = 2'd3
  } path_sel_e;

endpackage

// File: rtl/bank_direct_path.sv
module bank_direct_path #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OPND_W = 8,
  localparam int unsigned BANK_W = ADDR_W - OPND_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic [ADDR_W-1:0] addr_o
);

  assign addr_o = {bank_i, opnd_i};

endmodule

// File: rtl/window_offset_adder.sv
module window_offset_adder #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OPND_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OPND_W-1:0] offs_i,
  output logic [ADDR_W-1:0] sum_o
);

  logic [ADDR_W-1:0] offs_ext;

  generate
    if (OPND_W < ADDR_W) begin : g_extend
      assign offs_ext = {{(ADDR_W-OPND_W){1'b0}}, offs_i};
    end else begin : g_trunc
      assign offs_ext = offs_i[ADDR_W-1:0];
    end
  endgenerate

  // carry out of the top bit is dropped: modulo 2**ADDR_W
  assign sum_o = base_i + offs_ext;

endmodule

// File: rtl/access_map_path.sv
module access_map_path #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OPND_W = 8,
  localparam int unsigned HI_W = ADDR_W - OPND_W
) (
  input  logic [OPND_W-1:0] opnd_i,
  output logic [ADDR_W-1:0] low0_addr_o,
  output logic [ADDR_W-1:0] sfr_addr_o
);

  localparam logic [HI_W-1:0] BANK_ZERO = '0;
  localparam logic [HI_W-1:0] BANK_TOP  = '1;

  assign low0_addr_o = {BANK_ZERO, opnd_i};
  assign sfr_addr_o  = {BANK_TOP, opnd_i};

endmodule

// File: rtl/addr_out_reg.sv
module addr_out_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/dmem_addr_remap.sv
module dmem_addr_remap
  import dmem_remap_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned OPND_W   = DEF_OPND_W,
  parameter int unsigned WIN_SPAN = DEF_WIN_SPAN,
  localparam int unsigned BANK_W  = ADDR_W - OPND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              acc_bank_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              ext_en_i,
  input  logic              ind_op_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              ind_bypass_o
);

  localparam logic [OPND_W-1:0] SPAN_LIM = OPND_W'(WIN_SPAN);

  logic [ADDR_W-1:0] banked_addr;
  logic [ADDR_W-1:0] low0_addr;
  logic [ADDR_W-1:0] sfr_addr;
  logic [ADDR_W-1:0] win_addr;
  logic [ADDR_W-1:0] next_addr;
  path_sel_e         path_sel;

  bank_direct_path #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) i_banked (
    .bank_i (bsr_i),
    .opnd_i (opnd_i),
    .addr_o (banked_addr)
  );

  access_map_path #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) i_amap (
    .opnd_i      (opnd_i),
    .low0_addr_o (low0_addr),
    .sfr_addr_o  (sfr_addr)
  );

  window_offset_adder #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) i_win (
    .base_i (ptr_i),
    .offs_i (opnd_i),
    .sum_o  (win_addr)
  );

  // path choice: bank select first, then the SFR half, then window vs bank 0
  always_comb begin
    if (acc_bank_i)                path_sel = PATH_BANKED;
    else if (opnd_i >= SPAN_LIM)   path_sel = PATH_SFR;
    else if (ext_en_i && !ind_op_i) path_sel = PATH_WINDOW;
    else                           path_sel = PATH_LOW0;
  end

  always_comb begin
    unique case (path_sel)
      PATH_BANKED: next_addr = banked_addr;
      PATH_SFR:    next_addr = sfr_addr;
      PATH_WINDOW: next_addr = win_addr;
      default:     next_addr = low0_addr;
    endcase
  end

  addr_out_reg #(.WIDTH(ADDR_W + 1)) i_oreg (
    .clk (clk),
    .rst (rst),
    .d_i ({ind_op_i, next_addr}),
    .q_o ({ind_bypass_o, phys_addr_o})
  );

endmodule

// File: rtl/dmem_addr_remap_chk.sv
module dmem_addr_remap_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned OPND_W   = 8,
  parameter int unsigned WIN_SPAN = 96,
  localparam int unsigned BANK_W  = ADDR_W - OPND_W
) (
  input logic              clk,
  input logic              rst,
  input logic [OPND_W-1:0] opnd_i,
  input logic              acc_bank_i,
  input logic [BANK_W-1:0] bsr_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              ext_en_i,
  input logic              ind_op_i,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic              ind_bypass_o
);

  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic primed_q = 1'b0;
  always_ff @(posedge clk) primed_q <= !rst;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    !primed_q |-> (phys_addr_o == '0 && !ind_bypass_o));

  // R2
  bank_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_bank_i)) |->
      phys_addr_o == {$past(bsr_i), $past(opnd_i)});

  // R4
  sfr_region_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && !$past(acc_bank_i) && $past(opnd_i) >= OPND_W'(WIN_SPAN)) |->
      phys_addr_o == {TOP_BANK, $past(opnd_i)});

  // R3
  low_bank0_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && !$past(acc_bank_i) && $past(opnd_i) < OPND_W'(WIN_SPAN) &&
     (!$past(ext_en_i) || $past(ind_op_i))) |->
      phys_addr_o == ADDR_W'($past(opnd_i)));

  // R5
  window_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && !$past(acc_bank_i) && $past(opnd_i) < OPND_W'(WIN_SPAN) &&
     $past(ext_en_i) && !$past(ind_op_i)) |->
      phys_addr_o == ADDR_W'($past(ptr_i) + ADDR_W'($past(opnd_i))));

  // R6
  bypass_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> ind_bypass_o == $past(ind_op_i));

endmodule

bind dmem_addr_remap dmem_addr_remap_chk #(
  .ADDR_W(ADDR_W), .OPND_W(OPND_W), .WIN_SPAN(WIN_SPAN)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .opnd_i       (opnd_i),
  .acc_bank_i   (acc_bank_i),
  .bsr_i        (bsr_i),
  .ptr_i        (ptr_i),
  .ext_en_i     (ext_en_i),
  .ind_op_i     (ind_op_i),
  .phys_addr_o  (phys_addr_o),
  .ind_bypass_o (ind_bypass_o)
);

// File: tb/test_dmem_addr_remap.sv
module test_dmem_addr_remap;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  opnd;
  logic        acc;
  logic [3:0]  bsr;
  logic [11:0] ptr;
  logic        ext;
  logic        ind;
  logic [11:0] phys;
  logic        byp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dmem_addr_remap i_dmem_addr_remap (
    .clk (clk), .rst (rst), .opnd_i (opnd), .acc_bank_i (acc), .bsr_i (bsr),
    .ptr_i (ptr), .ext_en_i (ext), .ind_op_i (ind),
    .phys_addr_o (phys), .ind_bypass_o (byp)
  );

  function automatic int expect_addr(int o, bit a, int b, int p, bit e, bit i);
    if (a) return b * 256 + o;
    if (o >= 96) return 3840 + o;
    if (e && !i) return (p + o) % 4096;
    return o;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%03h expected=%03h", req, got, exp);
    end
  endtask

  task automatic drive(int o, bit a, int b, int p, bit e, bit i);
    @(negedge clk);
    opnd = 8'(o); acc = a; bsr = 4'(b); ptr = 12'(p); ext = e; ind = i;
  endtask

  // drive, let one rising edge pass, check at the following falling edge
  task automatic apply(int o, bit a, int b, int p, bit e, bit i, string req);
    string tag;
    drive(o, a, b, p, e, i);
    @(negedge clk);
    if (req != "") tag = req;
    else if (a) tag = "R2";
    else if (o >= 96) tag = "R4";
    else if (e && !i) tag = "R5";
    else tag = "R3";
    check(tag, int'(phys), expect_addr(o, a, b, p, e, i));
    check("R6", int'(byp), int'(i));
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bases[4] = '{12'h120, 12'hFF0, 12'h000, 12'h7A5};
    int banks[4] = '{0, 15, 5, 10};
    rst = 1'b1; opnd = 8'hAB; acc = 1'b1; bsr = 4'h7; ptr = 12'h345; ext = 1'b1; ind = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(phys), 0);
    check("R1", int'(byp), 0);
    rst = 1'b0;

    // R8 boundary and R9 hidden bank 0 with pointer 120h
    apply(8'h5F, 1'b0, 0, 12'h120, 1'b1, 1'b0, "R8");
    check("R8", int'(phys), 12'h17F);
    apply(8'h60, 1'b0, 0, 12'h120, 1'b1, 1'b0, "R8");
    check("R8", int'(phys), 12'hF60);
    apply(8'h10, 1'b0, 0, 12'h120, 1'b1, 1'b0, "R5");
    check("R9", int'(phys), 12'h130);
    apply(8'h10, 1'b1, 0, 12'h120, 1'b1, 1'b0, "R9");
    check("R9", int'(phys), 12'h010);
    // R5 wrap past FFFh
    apply(8'h5F, 1'b0, 0, 12'hFF0, 1'b1, 1'b0, "R5");
    check("R5", int'(phys), 12'h04F);
    // R6 window and bypass requested together: bypass wins
    apply(8'h20, 1'b0, 0, 12'h300, 1'b1, 1'b1, "R6");
    check("R6", int'(phys), 12'h020);

    // R7: output holds until the rising edge
    apply(8'h22, 1'b1, 3, 0, 1'b0, 1'b0, "R7");
    drive(8'h70, 1'b0, 0, 0, 1'b0, 1'b1);
    #1;
    check("R7", int'(phys), 12'h322);
    check("R7", int'(byp), 0);
    @(negedge clk);
    check("R7", int'(phys), 12'hF70);
    check("R7", int'(byp), 1);

    // near-exhaustive sweep: every operand, every mode bit combination
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 8; m++)
        for (int o = 0; o < 256; o++)
          apply(o, m[0], banks[k], bases[k], m[1], m[2], "");

    // random pointers and banks
    for (int n = 0; n < 2000; n++)
      apply($urandom_range(255), 1'($urandom), $urandom_range(15),
            $urandom_range(4095), 1'($urandom), 1'($urandom), "");

    // R1 again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", int'(phys), 0);
    check("R1", int'(byp), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule